// File: doc/BRIEF.md
# Deduplicating Prefetch Request Queue

This block sits between a prefetch address predictor and the memory request port. Each cycle the predictor may offer one candidate address. The block accepts every candidate. It reduces the address to its cache-block tag and compares that tag against two sets of stored tags: the blocks still waiting in its request FIFO, and a ring of the blocks that most recently left that FIFO. If either set holds the same block, the candidate is a redundant prefetch. It is discarded and counted. Otherwise it is written into the FIFO.

The FIFO presents its oldest entry on a valid/ready request port as a block-aligned address. An entry leaves the FIFO when the memory side takes it. An entry also leaves when a new, non-redundant candidate arrives while the FIFO is full and nothing is taken that cycle: the oldest entry is pushed out to make room. In both cases the departing tag is written into the history ring. The ring overwrites its oldest slot, so later candidates for the same block are still caught after the request has gone. A saturating counter reports how many candidates were discarded.

Top module: `pfq_dedup_top`

## Requirements
- R1: After reset, pf_valid is 0, dup_count is 0, and both the queue and the history ring hold nothing.
- R2: A candidate that is not discarded appears on the request port in the cycle after it is offered. pf_addr carries the candidate's bits [31:6] with bits [5:0] zero. Entries leave the port in arrival order.
- R3: A candidate whose block matches an entry waiting in the queue is discarded, is not enqueued, and raises dup_count by one.
- R4: A candidate that matches the entry leaving the queue in the same cycle (pf_valid and pf_ready both high) is still discarded.
- R5: Every block that leaves the queue is written into the history ring. A later candidate that matches the ring is discarded and counted.
- R6: With 8 entries queued, pf_ready low, and a new non-redundant candidate, the oldest entry is pushed into the history ring and the candidate is enqueued. The port then shows the second-oldest entry.
- R7: The ring keeps the 16 most recent departures. A block whose departure is older than that is accepted again.
- R8: dup_count is 16 bits wide and stops at 65535.
- R9: While pf_valid is high and pf_ready is low, pf_addr stays unchanged as long as no candidate is offered.
- R10: Matching compares only bits [31:6], so two addresses that differ only in bits [5:0] are treated as one block.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cand_valid | input | 1 | A predicted address is offered this cycle |
| cand_addr | input | 32 | Predicted byte address |
| pf_valid | output | 1 | Queue head is available as a request |
| pf_ready | input | 1 | Memory side takes the head this cycle |
| pf_addr | output | 32 | Block-aligned request address |
| dup_count | output | 16 | Saturating count of discarded candidates |

## Verification
The checker runs on every cycle and covers the port-level rules. It checks that the counter moves by at most one step and only when a candidate was offered, and that the counter holds at its ceiling. It checks that request addresses are always block aligned, that a request stays stable under backpressure when no candidate arrives, that a new request follows a candidate, and that occupancy never exceeds the queue depth. Which candidates get discarded depends on what the queue and the ring held earlier, so only the bench's scenarios can show it. Those scenarios cover the same-cycle departure match, push-out on overflow, forgetting after the ring wraps, and saturation.

// File: rtl/pfq_pkg.sv
`timescale 1ns/1ps
package pfq_pkg;
   typedef enum logic [1:0] {
      ACT_IDLE  = 2'd0,
      ACT_DROP  = 2'd1,
      ACT_ENQ   = 2'd2,
      ACT_SHOVE = 2'd3
   } cand_act_e;

   function automatic bit is_pow2(input int unsigned v);
      return (v != 0) && ((v & (v - 1)) == 0);
   endfunction
endpackage

// File: rtl/pfq_tag_match.sv
`timescale 1ns/1ps
module pfq_tag_match #(
   parameter int unsigned N     = 8,
   parameter int unsigned TAG_W = 26
) (
   input  logic [N-1:0][TAG_W-1:0] ent_tag,
   input  logic [N-1:0]            ent_vld,
   input  logic [TAG_W-1:0]        key,
   output logic                    hit
);
   logic [N-1:0] hit_vec;

   for (genvar i = 0; i < N; i++) begin : g_cmp
      assign hit_vec[i] = ent_vld[i] && (ent_tag[i] == key);
   end

   assign hit = |hit_vec;
endmodule

// File: rtl/pfq_queue.sv
`timescale 1ns/1ps
module pfq_queue #(
   parameter int unsigned DEPTH = 8,
   parameter int unsigned TAG_W = 26
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        push,
   input  logic [TAG_W-1:0]            push_tag,
   input  logic                        pop,
   output logic [TAG_W-1:0]            head_tag,
   output logic                        empty,
   output logic                        full,
   output logic [$clog2(DEPTH):0]      count,
   output logic [DEPTH-1:0][TAG_W-1:0] slot_tag,
   output logic [DEPTH-1:0]            slot_vld
);
   localparam int unsigned PW = $clog2(DEPTH);

   if (!pfq_pkg::is_pow2(DEPTH)) begin : g_bad_depth
      $error("pfq_queue: DEPTH must be a power of two");
   end

   logic [PW-1:0] head_q, tail_q;
   logic [PW:0]   cnt_q;
   logic [DEPTH-1:0][TAG_W-1:0] mem_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         head_q <= '0;
         tail_q <= '0;
         cnt_q  <= '0;
         mem_q  <= '0;
      end else begin
         if (push) begin
            mem_q[tail_q] <= push_tag;
            tail_q        <= tail_q + 1'b1;
         end
         if (pop) head_q <= head_q + 1'b1;
         case ({push, pop})
            2'b10:   cnt_q <= cnt_q + 1'b1;
            2'b01:   cnt_q <= cnt_q - 1'b1;
            default: cnt_q <= cnt_q;
         endcase
      end
   end

   for (genvar i = 0; i < DEPTH; i++) begin : g_slot
      logic [PW-1:0] rel;
      assign rel         = PW'(i) - head_q;
      assign slot_vld[i] = ({1'b0, rel} < cnt_q);
      assign slot_tag[i] = mem_q[i];
   end

   assign head_tag = mem_q[head_q];
   assign empty    = (cnt_q == '0);
   assign full     = (cnt_q == (PW+1)'(DEPTH));
   assign count    = cnt_q;
endmodule

// File: rtl/pfq_hist_ring.sv
`timescale 1ns/1ps
module pfq_hist_ring #(
   parameter int unsigned DEPTH = 16,
   parameter int unsigned TAG_W = 26
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        wr_en,
   input  logic [TAG_W-1:0]            wr_tag,
   output logic [DEPTH-1:0][TAG_W-1:0] ent_tag,
   output logic [DEPTH-1:0]            ent_vld
);
   localparam int unsigned PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

   if (!pfq_pkg::is_pow2(DEPTH)) begin : g_bad_depth
      $error("pfq_hist_ring: DEPTH must be a power of two");
   end

   logic [PW-1:0]              wptr_q;
   logic [DEPTH-1:0][TAG_W-1:0] tag_q;
   logic [DEPTH-1:0]            vld_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wptr_q <= '0;
         tag_q  <= '0;
         vld_q  <= '0;
      end else if (wr_en) begin
         tag_q[wptr_q] <= wr_tag;
         vld_q[wptr_q] <= 1'b1;
         wptr_q        <= (DEPTH > 1) ? wptr_q + 1'b1 : '0;
      end
   end

   assign ent_tag = tag_q;
   assign ent_vld = vld_q;
endmodule

// File: rtl/pfq_sat_count.sv
`timescale 1ns/1ps
module pfq_sat_count #(
   parameter int unsigned W = 16
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         inc,
   output logic [W-1:0] value
);
   logic [W-1:0] val_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                    val_q <= '0;
      else if (inc && (val_q != '1)) val_q <= val_q + 1'b1;
   end

   assign value = val_q;
endmodule

// File: rtl/pfq_dedup_top.sv
`timescale 1ns/1ps
module pfq_dedup_top #(
   parameter int unsigned ADDR_W  = 32,
   parameter int unsigned BLK_LSB = 6,
   parameter int unsigned Q_DEPTH = 8,
   parameter int unsigned H_DEPTH = 16,
   parameter int unsigned CNT_W   = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cand_valid,
   input  logic [ADDR_W-1:0] cand_addr,
   output logic              pf_valid,
   input  logic              pf_ready,
   output logic [ADDR_W-1:0] pf_addr,
   output logic [CNT_W-1:0]  dup_count
);
   import pfq_pkg::*;

   localparam int unsigned TAG_W = ADDR_W - BLK_LSB;
   localparam int unsigned QC_W  = $clog2(Q_DEPTH) + 1;

   if (BLK_LSB >= ADDR_W) begin : g_bad_blk
      $error("pfq_dedup_top: BLK_LSB must be below ADDR_W");
   end
   if (CNT_W < 1) begin : g_bad_cnt
      $error("pfq_dedup_top: CNT_W must be at least 1");
   end

   logic [TAG_W-1:0] cand_tag;
   logic [TAG_W-1:0] head_tag;
   logic             q_empty, q_full;
   logic [QC_W-1:0]  q_count;
   logic [Q_DEPTH-1:0][TAG_W-1:0] q_slot_tag;
   logic [Q_DEPTH-1:0]            q_slot_vld;
   logic             q_hit, h_hit;
   logic             deq, push, pop;
   cand_act_e        act;

   assign cand_tag = cand_addr[ADDR_W-1:BLK_LSB];
   assign pf_valid = !q_empty;
   assign deq      = pf_valid && pf_ready;

   always_comb begin
      if (!cand_valid)                act = ACT_IDLE;
      else if (q_hit || h_hit)        act = ACT_DROP;
      else if (q_full && !deq)        act = ACT_SHOVE;
      else                            act = ACT_ENQ;
   end

   assign push = (act == ACT_ENQ) || (act == ACT_SHOVE);
   assign pop  = deq || (act == ACT_SHOVE);

   pfq_queue #(.DEPTH(Q_DEPTH), .TAG_W(TAG_W)) u_queue (
      .clk      (clk),
      .rst_n    (rst_n),
      .push     (push),
      .push_tag (cand_tag),
      .pop      (pop),
      .head_tag (head_tag),
      .empty    (q_empty),
      .full     (q_full),
      .count    (q_count),
      .slot_tag (q_slot_tag),
      .slot_vld (q_slot_vld)
   );

   pfq_tag_match #(.N(Q_DEPTH), .TAG_W(TAG_W)) u_qmatch (
      .ent_tag (q_slot_tag),
      .ent_vld (q_slot_vld),
      .key     (cand_tag),
      .hit     (q_hit)
   );

   if (H_DEPTH > 0) begin : g_hist
      logic [H_DEPTH-1:0][TAG_W-1:0] h_tag;
      logic [H_DEPTH-1:0]            h_vld;

      pfq_hist_ring #(.DEPTH(H_DEPTH), .TAG_W(TAG_W)) u_ring (
         .clk     (clk),
         .rst_n   (rst_n),
         .wr_en   (pop),
         .wr_tag  (head_tag),
         .ent_tag (h_tag),
         .ent_vld (h_vld)
      );

      pfq_tag_match #(.N(H_DEPTH), .TAG_W(TAG_W)) u_hmatch (
         .ent_tag (h_tag),
         .ent_vld (h_vld),
         .key     (cand_tag),
         .hit     (h_hit)
      );
   end else begin : g_no_hist
      assign h_hit = 1'b0;
   end

   pfq_sat_count #(.W(CNT_W)) u_dups (
      .clk   (clk),
      .rst_n (rst_n),
      .inc   (act == ACT_DROP),
      .value (dup_count)
   );

   assign pf_addr = {head_tag, {BLK_LSB{1'b0}}};
endmodule

// File: rtl/pfq_dedup_chk.sv
`timescale 1ns/1ps
module pfq_dedup_chk #(
   parameter int unsigned ADDR_W  = 32,
   parameter int unsigned BLK_LSB = 6,
   parameter int unsigned Q_DEPTH = 8,
   parameter int unsigned CNT_W   = 16,
   parameter int unsigned QC_W    = 4
) (
   input logic              clk,
   input logic              rst_n,
   input logic              cand_valid,
   input logic              pf_valid,
   input logic              pf_ready,
   input logic [ADDR_W-1:0] pf_addr,
   input logic [CNT_W-1:0]  dup_count,
   input logic [QC_W-1:0]   q_count
);
   // R2 / R10: requests are block aligned
   assert_aligned_R2: assert property (@(posedge clk) disable iff (!rst_n)
      pf_valid |-> (pf_addr[BLK_LSB-1:0] == '0));

   // R2: a new request needs a candidate in the cycle before
   assert_rise_needs_cand_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(pf_valid) |-> $past(cand_valid));

   // R3: the counter moves by at most one
   assert_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (dup_count == $past(dup_count)) || (dup_count == $past(dup_count) + 1'b1));

   // R3: the counter moves only when a candidate was offered
   assert_inc_cause_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !cand_valid |=> $stable(dup_count));

   // R8: saturation
   assert_sat_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (dup_count == '1) |=> (dup_count == '1));

   // R9: head held under backpressure with no candidate
   assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (pf_valid && !pf_ready && !cand_valid) |=> (pf_valid && $stable(pf_addr)));

   // R6: occupancy bounded by depth
   assert_no_overflow_R6: assert property (@(posedge clk) disable iff (!rst_n)
      q_count <= QC_W'(Q_DEPTH));
endmodule

bind pfq_dedup_top pfq_dedup_chk #(
   .ADDR_W  (ADDR_W),
   .BLK_LSB (BLK_LSB),
   .Q_DEPTH (Q_DEPTH),
   .CNT_W   (CNT_W),
   .QC_W    (QC_W)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .cand_valid (cand_valid),
   .pf_valid   (pf_valid),
   .pf_ready   (pf_ready),
   .pf_addr    (pf_addr),
   .dup_count  (dup_count),
   .q_count    (q_count)
);

// File: tb/sim_pfq_dedup_top.sv
`timescale 1ns/1ps
module sim_pfq_dedup_top;
   logic        clk = 1'b0;
   logic        rst_n;
   logic        cand_valid;
   logic [31:0] cand_addr;
   logic        pf_valid;
   logic        pf_ready;
   logic [31:0] pf_addr;
   logic [15:0] dup_count;

   int checks = 0;
   int errors = 0;
   bit done   = 1'b0;

   always #2.5 clk = ~clk;

   pfq_dedup_top u0 (
      .clk        (clk),
      .rst_n      (rst_n),
      .cand_valid (cand_valid),
      .cand_addr  (cand_addr),
      .pf_valid   (pf_valid),
      .pf_ready   (pf_ready),
      .pf_addr    (pf_addr),
      .dup_count  (dup_count)
   );

   function automatic logic [31:0] blk(input int unsigned grp, input int unsigned n,
                                       input int unsigned off);
      return 32'h1000_0000 + (grp << 16) + (n << 6) + (off & 63);
   endfunction

   task automatic chk(input bit ok, input string req, input logic [31:0] act,
                      input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic do_reset();
      rst_n = 1'b0; cand_valid = 1'b0; cand_addr = '0; pf_ready = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
   endtask

   task automatic offer(input logic [31:0] a);
      cand_valid = 1'b1; cand_addr = a;
      @(negedge clk);
      cand_valid = 1'b0;
   endtask

   task automatic take(input logic [31:0] exp, input string req);
      chk(pf_valid && pf_addr == exp, req, pf_addr, exp);
      pf_ready = 1'b1;
      @(negedge clk);
      pf_ready = 1'b0;
   endtask

   task automatic t_reset();
      do_reset();
      chk(pf_valid == 1'b0, "R1 pf_valid", 32'(pf_valid), 0);
      chk(dup_count == 0, "R1 dup_count", 32'(dup_count), 0);
   endtask

   task automatic t_basic();
      offer(blk(0, 1, 20));
      chk(pf_valid && pf_addr == blk(0, 1, 0), "R2 head", pf_addr, blk(0, 1, 0));
      offer(blk(0, 1, 8));
      chk(dup_count == 1, "R3 R10 dup in queue", 32'(dup_count), 1);
      offer(blk(0, 2, 0));
      take(blk(0, 1, 0), "R2 order first");
      take(blk(0, 2, 0), "R2 order second");
      chk(!pf_valid, "R3 no copy enqueued", 32'(pf_valid), 0);
   endtask

   task automatic t_filter();
      offer(blk(0, 1, 40));
      chk(dup_count == 2, "R5 dup in ring", 32'(dup_count), 2);
      chk(!pf_valid, "R5 not enqueued", 32'(pf_valid), 0);
   endtask

   task automatic t_same_cycle();
      offer(blk(0, 3, 0));
      pf_ready = 1'b1; cand_valid = 1'b1; cand_addr = blk(0, 3, 4);
      @(negedge clk);
      pf_ready = 1'b0; cand_valid = 1'b0;
      chk(dup_count == 3, "R4 departing match", 32'(dup_count), 3);
      chk(!pf_valid, "R4 queue empty", 32'(pf_valid), 0);
   endtask

   task automatic t_overflow();
      do_reset();
      for (int i = 0; i < 9; i++) offer(blk(1, i, 0));
      chk(pf_addr == blk(1, 1, 0), "R6 oldest pushed out", pf_addr, blk(1, 1, 0));
      chk(dup_count == 0, "R6 no drops", 32'(dup_count), 0);
      offer(blk(1, 0, 0));
      chk(dup_count == 1, "R6 R5 pushed-out in ring", 32'(dup_count), 1);
      for (int i = 1; i < 9; i++) take(blk(1, i, 0), "R6 drain order");
      chk(!pf_valid, "R6 drained", 32'(pf_valid), 0);
   endtask

   task automatic t_wrap();
      do_reset();
      for (int i = 0; i < 17; i++) begin
         offer(blk(2, i, 0));
         take(blk(2, i, 0), "R7 pass");
      end
      offer(blk(2, 0, 0));
      chk(dup_count == 0, "R7 forgotten block accepted", 32'(dup_count), 0);
      chk(pf_valid && pf_addr == blk(2, 0, 0), "R7 re-enqueued", pf_addr, blk(2, 0, 0));
      take(blk(2, 0, 0), "R7 pass again");
      offer(blk(2, 16, 0));
      chk(dup_count == 1, "R7 recent block caught", 32'(dup_count), 1);
   endtask

   task automatic t_hold();
      do_reset();
      offer(blk(3, 5, 0));
      offer(blk(3, 6, 0));
      repeat (4) @(negedge clk);
      chk(pf_valid && pf_addr == blk(3, 5, 0), "R9 held", pf_addr, blk(3, 5, 0));
   endtask

   task automatic t_sat();
      do_reset();
      offer(blk(4, 1, 0));
      cand_valid = 1'b1; cand_addr = blk(4, 1, 0);
      repeat (65600) @(negedge clk);
      cand_valid = 1'b0;
      @(negedge clk);
      chk(dup_count == 16'hFFFF, "R8 saturated", 32'(dup_count), 32'hFFFF);
      chk(pf_valid && pf_addr == blk(4, 1, 0), "R8 queue intact", pf_addr, blk(4, 1, 0));
   endtask

   initial begin
      t_reset();
      t_basic();
      t_filter();
      t_same_cycle();
      t_overflow();
      t_wrap();
      t_hold();
      t_sat();
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      #(5.0 * 190000);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog actual=%h expected=%h", 0, 1);
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end
endmodule